// File: doc/BRIEF.md
# Shift-and-Add Multiply Step Unit

This block carries out a single step of a conditional shift-and-add multiply. Each step shifts the running partial product one place to the right and adds the multiplicand only when the low bit of the Y register is set. The bit that enters the top of the partial product is the true sign of the previous sum, taken as N xor V from the stored flags. Y also shifts right, and the bit that drops off the bottom of the partial product enters Y at its top. The step updates the N, Z, V and C flags from its own addition. A full 32-by-32 product comes from repeating the step 32 times, then running one more step with a zero multiplicand.

The unit has two ways to drive the step. Software-style use loads the partial product, Y and flags from ports, then issues single steps, one per cycle. The built-in sequencer starts from a cleared partial product and clear flags, with the multiplier in Y. It runs the DATA_W add steps and the final shift-only step on its own. When it finishes, {acc_out, y_out} holds the 64-bit product of a signed multiplicand and an unsigned multiplier. The multiplicand can be a register value or a sign-extended immediate.

Top module: `mstep_unit`

## Requirements
- R1: After reset, acc_out, y_out and flags_out are zero, and busy and done are low.
- R2: An accepted step forms the shifted partial product as {N xor V, acc[DATA_W-1:1]} from the stored state. The shifted-in bit is N xor V, not N alone.
- R3: When y[0] is 0 the multiplicand term is zero and acc becomes the shifted partial product. When y[0] is 1, acc becomes the shifted partial product plus the multiplicand, modulo 2^DATA_W.
- R4: Every step sets y to {acc[0], y[DATA_W-1:1]}, using the values from before the step.
- R5: flags_out uses bit 3 for N, bit 2 for Z, bit 1 for V and bit 0 for C, all set by the step's addition. N is the sum's top bit and Z means the sum is zero. V is two's-complement add overflow and C is the carry out of the top bit.
- R6: With use_imm high, the multiplicand is imm_in sign-extended from IMM_W bits, and b_in is not used.
- R7: A load while idle copies acc_in, y_in and flags_in (same bit layout as R5) into the state on the next edge.
- R8: A run_start while idle clears acc and the flags, loads y from y_in and latches the multiplicand. It then runs DATA_W add steps and one step with a zero multiplicand. busy is high for DATA_W+1 cycles, and done pulses for one cycle as busy falls. {acc_out, y_out} then equals the signed multiplicand times the unsigned y_in, modulo 2^(2*DATA_W), with V and C clear.
- R9: While busy, load, step and run_start are ignored, and changes on b_in, imm_in, use_imm and y_in have no effect on the product. With no accepted request while idle, the state holds.
- R10: When requests arrive together while idle, run_start wins over load, and load wins over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Start an automatic multiply sequence |
| load | input | 1 | Load acc, y and flags from the input ports |
| step | input | 1 | Perform one multiply step |
| use_imm | input | 1 | Select the immediate as the multiplicand |
| b_in | input | DATA_W | Register multiplicand |
| imm_in | input | IMM_W | Immediate multiplicand, sign-extended |
| acc_in | input | DATA_W | Partial product value for load |
| y_in | input | DATA_W | Y value for load, or multiplier for run_start |
| flags_in | input | 4 | Flags for load: {N, Z, V, C} |
| acc_out | output | DATA_W | Current partial product |
| y_out | output | DATA_W | Current Y register |
| flags_out | output | 4 | Current flags {N, Z, V, C} |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence finishes |

## Verification
Single steps start from loaded states. Each state is picked to separate one behaviour:

- A clear Y bit 0 shows that the multiplicand is gated off.
- A sum that overflows, followed by a second step, tells N xor V apart from N alone as the shifted-in bit.
- A negative immediate alongside a garbage register value shows which multiplicand source is used.
- A sum that wraps to zero shows the Z and C flags.

Full sequences use several multiplicand and multiplier pairs:

- small positive values;
- all-ones times all-ones, which exercises the signed multiplicand against the unsigned multiplier;
- the most negative multiplicand;
- an immediate multiplicand.

These show that the final zero-multiplicand step and the Y chaining give the exact 64-bit product. One sequence is hit with load, step, run_start and operand changes while busy. Simultaneous requests check the priority order.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

   localparam int FLAG_W = 4;

   // Flag layout: [3] N, [2] Z, [1] V, [0] C
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } mstep_flags_t;

   localparam mstep_flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/mstep_opsel.sv
module mstep_opsel #(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 13,
   parameter bit IMM_SIGNED = 1'b1
) (
   input  logic [DATA_W-1:0] reg_val,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic              pick_imm,
   output logic [DATA_W-1:0] mcand
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (IMM_SIGNED) begin : g_sext
         assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
      end else begin : g_zext
         assign imm_ext = {{EXT_W{1'b0}}, imm_val};
      end
   endgenerate

   assign mcand = pick_imm ? imm_ext : reg_val;

endmodule

// File: rtl/mstep_core.sv
module mstep_core
   import mstep_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] acc_cur,
   input  logic [DATA_W-1:0] y_cur,
   input  mstep_flags_t      fl_cur,
   input  logic [DATA_W-1:0] mcand,
   output logic [DATA_W-1:0] acc_nxt,
   output logic [DATA_W-1:0] y_nxt,
   output mstep_flags_t      fl_nxt
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] addend;
   logic [DATA_W:0]   wide_sum;

   always_comb begin
      // true sign of the previous (DATA_W+1)-bit sum enters at the top
      shifted  = {fl_cur.n ^ fl_cur.v, acc_cur[MSB:1]};
      addend   = y_cur[0] ? mcand : '0;
      wide_sum = {1'b0, shifted} + {1'b0, addend};

      acc_nxt  = wide_sum[MSB:0];
      y_nxt    = {acc_cur[0], y_cur[MSB:1]};

      fl_nxt.n = wide_sum[MSB];
      fl_nxt.z = (wide_sum[MSB:0] == '0);
      fl_nxt.v = (shifted[MSB] == addend[MSB]) && (wide_sum[MSB] != shifted[MSB]);
      fl_nxt.c = wide_sum[DATA_W];
   end

endmodule

// File: rtl/mstep_ctrl.sv
module mstep_ctrl #(
   parameter int STEPS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_req,
   input  logic load_req,
   input  logic step_req,
   output logic take_run,
   output logic take_load,
   output logic take_step,
   output logic running,
   output logic last_step,
   output logic fin_pulse
);
   localparam int CNT_W = $clog2(STEPS + 1);

   logic [CNT_W-1:0] cnt_q;

   assign take_run  = run_req & ~running;
   assign take_load = load_req & ~running & ~run_req;
   assign take_step = step_req & ~running & ~run_req & ~load_req;
   assign last_step = running && (cnt_q == CNT_W'(STEPS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running   <= 1'b0;
         cnt_q     <= '0;
         fin_pulse <= 1'b0;
      end else begin
         fin_pulse <= 1'b0;
         if (take_run) begin
            running <= 1'b1;
            cnt_q   <= '0;
         end else if (running) begin
            if (last_step) begin
               running   <= 1'b0;
               cnt_q     <= '0;
               fin_pulse <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
   import mstep_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 13,
   parameter bit IMM_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_start,
   input  logic              load,
   input  logic              step,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] b_in,
   input  logic [IMM_W-1:0]  imm_in,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] y_in,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] y_out,
   output logic [FLAG_W-1:0] flags_out,
   output logic              busy,
   output logic              done
);
   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("mstep_unit: DATA_W must be at least 4");
      end
      if (IMM_W < 2 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("mstep_unit: IMM_W must be in 2..DATA_W-1");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q, y_q, mc_q;
   mstep_flags_t      fl_q;

   logic [DATA_W-1:0] sel_mc, core_mc;
   logic [DATA_W-1:0] acc_nxt, y_nxt;
   mstep_flags_t      fl_nxt;

   logic take_run, take_load, take_step, running, last_step, fin_pulse;

   mstep_opsel #(
      .DATA_W    (DATA_W),
      .IMM_W     (IMM_W),
      .IMM_SIGNED(IMM_SIGNED)
   ) u_opsel (
      .reg_val (b_in),
      .imm_val (imm_in),
      .pick_imm(use_imm),
      .mcand   (sel_mc)
   );

   mstep_ctrl #(
      .STEPS(DATA_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_req  (run_start),
      .load_req (load),
      .step_req (step),
      .take_run (take_run),
      .take_load(take_load),
      .take_step(take_step),
      .running  (running),
      .last_step(last_step),
      .fin_pulse(fin_pulse)
   );

   // sequenced steps use the latched multiplicand; the closing step adds zero
   always_comb begin
      if (running) core_mc = last_step ? '0 : mc_q;
      else         core_mc = sel_mc;
   end

   mstep_core #(
      .DATA_W(DATA_W)
   ) u_core (
      .acc_cur(acc_q),
      .y_cur  (y_q),
      .fl_cur (fl_q),
      .mcand  (core_mc),
      .acc_nxt(acc_nxt),
      .y_nxt  (y_nxt),
      .fl_nxt (fl_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         y_q   <= '0;
         fl_q  <= FLAGS_CLEAR;
         mc_q  <= '0;
      end else if (take_run) begin
         acc_q <= '0;
         y_q   <= y_in;
         fl_q  <= FLAGS_CLEAR;
         mc_q  <= sel_mc;
      end else if (take_load) begin
         acc_q <= acc_in;
         y_q   <= y_in;
         fl_q  <= mstep_flags_t'(flags_in);
      end else if (take_step || running) begin
         acc_q <= acc_nxt;
         y_q   <= y_nxt;
         fl_q  <= fl_nxt;
      end
   end

   assign acc_out   = acc_q;
   assign y_out     = y_q;
   assign flags_out = fl_q;
   assign busy      = running;
   assign done      = fin_pulse;

endmodule

// File: rtl/mstep_unit_chk.sv
module mstep_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_start,
   input logic              load,
   input logic              step,
   input logic [DATA_W-1:0] acc_out,
   input logic [DATA_W-1:0] y_out,
   input logic [3:0]        flags_out,
   input logic              busy,
   input logic              done
);
   logic step_ok;
   assign step_ok = step && !busy && !load && !run_start;

   int unsigned run_len;
   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ok && !y_out[0]) |=>
         acc_out == {$past(flags_out[3] ^ flags_out[1]), $past(acc_out[DATA_W-1:1])});

   a_r4_y_shift: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok |=> y_out == {$past(acc_out[0]), $past(y_out[DATA_W-1:1])});

   a_r5_n_z: assert property (@(posedge clk) disable iff (!rst_n)
      step_ok |=> (flags_out[3] == acc_out[DATA_W-1]) && (flags_out[2] == (acc_out == '0)));

   a_r8_done_len: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && run_len == DATA_W + 1));

   a_r8_final_flags: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> flags_out[1:0] == 2'b00);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !step && !load && !run_start) |=>
         ($stable(acc_out) && $stable(y_out) && $stable(flags_out)));

endmodule

bind mstep_unit mstep_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_start(run_start),
   .load     (load),
   .step     (step),
   .acc_out  (acc_out),
   .y_out    (y_out),
   .flags_out(flags_out),
   .busy     (busy),
   .done     (done)
);

// File: tb/mstep_unit_test.sv
`timescale 1ns/1ps
module mstep_unit_test;
   localparam int DW = 32;
   localparam int IW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_start, load, step, use_imm;
   logic [DW-1:0] b_in, acc_in, y_in;
   logic [IW-1:0] imm_in;
   logic [3:0]    flags_in;
   logic [DW-1:0] acc_out, y_out;
   logic [3:0]    flags_out;
   logic          busy, done;

   always #5 clk = ~clk;

   mstep_unit #(.DATA_W(DW), .IMM_W(IW), .IMM_SIGNED(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .run_start(run_start), .load(load), .step(step),
      .use_imm(use_imm), .b_in(b_in), .imm_in(imm_in), .acc_in(acc_in), .y_in(y_in),
      .flags_in(flags_in), .acc_out(acc_out), .y_out(y_out), .flags_out(flags_out),
      .busy(busy), .done(done)
   );

   typedef struct {
      int          due;
      bit          full;
      logic [DW-1:0] acc;
      logic [DW-1:0] y;
      logic [3:0]  fl;
      logic        bsy;
      logic        dn;
      string       req;
   } exp_t;

   exp_t q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [DW-1:0] m_acc, m_y;
   logic [3:0]    m_fl;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // monitor: compares the outputs against queued expectations on their due cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         exp_t e;
         e = q.pop_front();
         if (e.full) begin
            cmp(e.req, "acc", {32'h0, acc_out}, {32'h0, e.acc});
            cmp(e.req, "y", {32'h0, y_out}, {32'h0, e.y});
            cmp(e.req, "flags", {60'h0, flags_out}, {60'h0, e.fl});
         end
         cmp(e.req, "busy", {63'h0, busy}, {63'h0, e.bsy});
         cmp(e.req, "done", {63'h0, done}, {63'h0, e.dn});
      end
   end

   function automatic logic [DW-1:0] sext(input logic [IW-1:0] v);
      return {{(DW-IW){v[IW-1]}}, v};
   endfunction

   // reference step written from R2..R5
   task automatic ref_step(input logic [DW-1:0] mc);
      logic [DW-1:0] sh, ad, s;
      logic [DW:0]   w;
      logic n, z, v, c;
      sh = {m_fl[3] ^ m_fl[1], m_acc[DW-1:1]};
      ad = m_y[0] ? mc : '0;
      w  = {1'b0, sh} + {1'b0, ad};
      s  = w[DW-1:0];
      n  = s[DW-1];
      z  = (s == '0);
      v  = (sh[DW-1] == ad[DW-1]) && (s[DW-1] != sh[DW-1]);
      c  = w[DW];
      m_y   = {m_acc[0], m_y[DW-1:1]};
      m_acc = s;
      m_fl  = {n, z, v, c};
   endtask

   task automatic push(input int due, input bit full, input logic bsy, input logic dn, input string req);
      exp_t e;
      e.due = due; e.full = full; e.acc = m_acc; e.y = m_y; e.fl = m_fl;
      e.bsy = bsy; e.dn = dn; e.req = req;
      q.push_back(e);
   endtask

   task automatic clr();
      run_start = 0; load = 0; step = 0; use_imm = 0;
      b_in = '0; imm_in = '0; acc_in = '0; y_in = '0; flags_in = '0;
   endtask

   task automatic do_load(input logic [DW-1:0] a, input logic [DW-1:0] y, input logic [3:0] f, input string req);
      @(negedge clk); clr();
      load = 1; acc_in = a; y_in = y; flags_in = f;
      m_acc = a; m_y = y; m_fl = f;
      push(cyc + 1, 1, 0, 0, req);
   endtask

   task automatic do_step(input logic [DW-1:0] b, input logic [IW-1:0] imm, input bit ui, input string req);
      @(negedge clk); clr();
      step = 1; b_in = b; imm_in = imm; use_imm = ui;
      ref_step(ui ? sext(imm) : b);
      push(cyc + 1, 1, 0, 0, req);
   endtask

   task automatic do_idle(input string req);
      @(negedge clk); clr();
      push(cyc + 1, 1, 0, 0, req);
   endtask

   // run with optional disturbance while busy (R9) and optional extra requests at start (R10)
   task automatic do_run(input logic [DW-1:0] b, input logic [IW-1:0] imm, input bit ui,
                         input logic [DW-1:0] mult, input bit disturb, input bit extra, input string req);
      logic [DW-1:0] mc;
      logic [63:0]   prod;
      int            t0;
      @(negedge clk); clr();
      run_start = 1; b_in = b; imm_in = imm; use_imm = ui; y_in = mult;
      if (extra) begin load = 1; step = 1; acc_in = 32'hDEAD_BEEF; flags_in = 4'hF; end
      mc   = ui ? sext(imm) : b;
      prod = {{DW{mc[DW-1]}}, mc} * {{DW{1'b0}}, mult};
      t0 = cyc;
      push(t0 + 1, 0, 1, 0, "R8");
      push(t0 + DW + 1, 0, 1, 0, "R8");
      m_acc = prod[63:32]; m_y = prod[31:0];
      m_fl  = {prod[63], (prod[63:32] == '0), 1'b0, 1'b0};
      push(t0 + DW + 2, 1, 0, 1, req);
      for (int k = 1; k <= DW + 1; k++) begin
         @(negedge clk); clr();
         if (disturb) begin
            b_in = 32'h1357_9BDF; imm_in = 13'h0AAA; use_imm = k[0]; y_in = 32'hFFFF_0000;
            if (k == 3)  begin load = 1; acc_in = 32'h1111_2222; flags_in = 4'hA; end
            if (k == 7)  step = 1;
            if (k == 11) run_start = 1;
            if (k == DW + 1) begin step = 1; load = 1; end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clr();
      m_acc = '0; m_y = '0; m_fl = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      cmp("R1", "acc", {32'h0, acc_out}, 64'h0);
      cmp("R1", "y", {32'h0, y_out}, 64'h0);
      cmp("R1", "flags", {60'h0, flags_out}, 64'h0);
      cmp("R1", "busy/done", {62'h0, busy, done}, 64'h0);
      rst_n = 1;

      // R7: load path, flags layout
      do_load(32'h0000_0005, 32'h0000_0002, 4'b1000, "R7");
      // R2/R3: y0=0 gates multiplicand, N^V=1 shifted in; R4 y shift
      do_step(32'h0000_1234, '0, 0, "R3_gate_off");
      // R3: y0=1 adds; carry out sets C (R5)
      do_step(32'h4000_0000, '0, 0, "R3_add");
      // R5 overflow, then R2 uses N^V (=0) rather than N (=1)
      do_load(32'hFFFF_FFFE, 32'h0000_0001, 4'b0000, "R7");
      do_step(32'h0000_0001, '0, 0, "R5_overflow");
      do_step(32'h0000_0001, '0, 0, "R2_n_xor_v");
      // R6: negative immediate replaces b_in
      do_load(32'h0, 32'h1, 4'b0000, "R7");
      do_step(32'hFFFF_FFFF, 13'h1000, 1, "R6_imm");
      // R5: sum wraps to zero -> Z and C
      do_load(32'h2, 32'h1, 4'b0000, "R7");
      do_step(32'h0, 13'h1FFF, 1, "R5_zero_carry");
      // R9: idle with no request holds
      do_idle("R9_idle_hold");
      // R8: full sequences
      do_run(32'd7, '0, 0, 32'd6, 0, 0, "R8_small");
      do_run(32'hFFFF_FFFF, '0, 0, 32'hFFFF_FFFF, 0, 0, "R8_signed_mcand");
      do_run(32'h8000_0000, '0, 0, 32'hFFFF_FFFF, 0, 0, "R8_most_negative");
      do_run(32'h0, 13'h1FFD, 1, 32'd1000, 0, 0, "R8_R6_imm_run");
      // R9: requests and operand changes while busy are ignored
      do_run(32'h0001_2345, '0, 0, 32'h89AB_CDEF, 1, 0, "R9_busy_ignore");
      // R10: run_start beats load and step
      do_run(32'd12345, '0, 0, 32'd678, 0, 1, "R10_run_wins");
      // R10: load beats step
      @(negedge clk); clr();
      load = 1; step = 1; acc_in = 32'h0F0F_0F0F; y_in = 32'h3; flags_in = 4'b0101; b_in = 32'h5;
      m_acc = 32'h0F0F_0F0F; m_y = 32'h3; m_fl = 4'b0101;
      push(cyc + 1, 1, 0, 0, "R10_load_wins");
      do_step(32'h7777_0000, '0, 0, "R4_after_load");

      repeat (4) @(negedge clk);
      clr();
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule